// File: doc/BRIEF.md
# Timestamped Fixed-Delay Data FIFO

This block holds back a stream of data words for a programmable number of clock cycles. A wrapping time base runs freely. When a word is accepted, the block adds the configured delay to the current time and stores that release time in the same memory entry as the word. A word reaches the output when the release time of the entry at the head of the queue equals the current time. Because the test is for equality, the time base can wrap without any word leaving early.

The pop decision is combinational from that comparison, so a word can be written on every clock cycle and each one still leaves on its own cycle. A delay below the internal latency of the path (two cycles) is raised to that minimum before it is added. An almost-full flag lets the source upstream slow itself down. A write that arrives while every entry is occupied is dropped, and a sticky overflow flag records the loss. Elaboration stops if the delay width is too narrow to hold the minimum latency.

Top module: `timed_delay_fifo`

## Requirements
- R1: A word sampled with `in_valid` high and delay D (2 <= D) appears on `out_data`, with `out_valid` high, exactly D clock edges after the edge that sampled it, with its value unchanged.
- R2: A configured delay of 0 or 1 is treated as 2, the minimum latency of the path.
- R3: The largest delay, 2^DELAY_BITS-1 (255 with defaults), is honoured. Wraparound of the time base never releases a word early or late.
- R4: Words written on consecutive cycles with one delay value leave on consecutive cycles, in order, with none lost. This holds for bursts longer than the storage depth.
- R5: A new delay value applies to words sampled after the change, once the earlier words have drained.
- R6: `out_valid` is high for exactly one cycle per released word and low otherwise. `out_data` changes only in a release cycle and keeps the last released word between releases.
- R7: `almost_full` is high while the number of stored words is at least AFULL_LEVEL (6 with defaults, depth 8) and low below it.
- R8: A word that reaches storage while all DEPTH entries are full and no word leaves in that cycle is dropped. `overflow` then rises and stays high until reset. Words already stored are still released on time.
- R9: During and after reset, `out_valid`, `almost_full` and `overflow` are 0 and any stored words are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | DATA_W | Input word |
| delay_cfg | input | DELAY_BITS | Delay in cycles applied to the word sampled now |
| out_valid | output | 1 | One-cycle pulse per released word |
| out_data | output | DATA_W | Released word, held until the next release |
| almost_full | output | 1 | Stored count at or above AFULL_LEVEL |
| overflow | output | 1 | Sticky: a word was dropped because storage was full |

## Verification
A lone word with a mid-range delay checks the exact release cycle and shows that the output holds its value afterwards. Delays of 0 and 1 show the clamp, and the maximum delay, run long enough to cross several time-base wraps, separates equality release from ordered comparison. A long every-cycle burst shows that the combinational pop keeps pace, and a short burst followed by a long one shows the delay switching cleanly. A burst held back by a long delay fills the storage, which shows the almost-full threshold, the dropped writes, the sticky overflow flag and its clearing by reset.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // Cycles from the sampling edge until an entry can be popped at the earliest:
  // one edge into the capture stage, one edge into storage.
  localparam int unsigned MIN_LAT = 2;
endpackage

// File: rtl/dly_rst_sync.sv
module dly_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dly_time_base.sv
module dly_time_base #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now
);
  logic [W-1:0] now_q, now_nxt;

  always_comb now_nxt = now_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_nxt;
  end

  assign now = now_q;
endmodule

// File: rtl/dly_stamp_fifo.sv
module dly_stamp_fifo #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned STAMP_W = 8,
  parameter int unsigned DEPTH   = 8,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [STAMP_W-1:0] wr_stamp,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  head_data,
  output logic [STAMP_W-1:0] head_stamp,
  output logic               empty,
  output logic [CNT_W-1:0]   count,
  output logic               ovf
);
  localparam int unsigned ENTRY_W = DATA_W + STAMP_W;

  // Word and release time share one memory entry.
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wr_ptr_q, wr_ptr_nxt, rd_ptr_q, rd_ptr_nxt;
  logic [CNT_W-1:0]   cnt_q, cnt_nxt;
  logic               ovf_q, ovf_nxt;
  logic               full, rd_acc, wr_acc;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full       = (cnt_q == CNT_W'(DEPTH));
    empty      = (cnt_q == '0);
    rd_acc     = rd_en && !empty;
    wr_acc     = wr_en && (!full || rd_acc);
    wr_ptr_nxt = wr_acc ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_nxt = rd_acc ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_nxt    = cnt_q;
    if (wr_acc && !rd_acc)      cnt_nxt = cnt_q + CNT_W'(1);
    else if (!wr_acc && rd_acc) cnt_nxt = cnt_q - CNT_W'(1);
    ovf_nxt    = ovf_q || (wr_en && !wr_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_nxt;
      rd_ptr_q <= rd_ptr_nxt;
      cnt_q    <= cnt_nxt;
      ovf_q    <= ovf_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr_q] <= {wr_stamp, wr_data};
  end

  assign {head_stamp, head_data} = mem[rd_ptr_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R7: occupancy never exceeds the storage depth
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R8: the loss flag is sticky until reset
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R8: a dropped write leaves the storage full
  a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (cnt_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/timed_delay_fifo.sv
module timed_delay_fifo #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned DELAY_BITS  = 8,
  parameter int unsigned DEPTH       = 8,
  parameter bit          AFULL_EN    = 1'b1,
  parameter int unsigned AFULL_LEVEL = DEPTH - 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     in_data,
  input  logic [DELAY_BITS-1:0] delay_cfg,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     out_data,
  output logic                  almost_full,
  output logic                  overflow
);
  import dly_pkg::*;

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  if (((2 ** DELAY_BITS) - 1) < MIN_LAT) begin : g_width_check
    $error("DELAY_BITS too narrow to express the minimum latency");
  end

  logic                  rst_sync_n;
  logic [DELAY_BITS-1:0] now;
  logic [DELAY_BITS-1:0] eff_delay;
  logic                  cap_vld_q, cap_vld_nxt;
  logic [DATA_W-1:0]     cap_data_q, cap_data_nxt;
  logic [DELAY_BITS-1:0] cap_stamp_q, cap_stamp_nxt;
  logic [DATA_W-1:0]     head_data;
  logic [DELAY_BITS-1:0] head_stamp;
  logic                  empty;
  logic [CNT_W-1:0]      count;
  logic                  rd_en;
  logic                  out_vld_q, out_vld_nxt;
  logic [DATA_W-1:0]     out_data_q, out_data_nxt;

  dly_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dly_time_base #(.W(DELAY_BITS)) u_time (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .now   (now)
  );

  // Capture stage: stamp the word with its absolute release time.
  always_comb begin
    eff_delay     = (delay_cfg < DELAY_BITS'(MIN_LAT)) ? DELAY_BITS'(MIN_LAT) : delay_cfg;
    cap_vld_nxt   = in_valid;
    cap_data_nxt  = in_valid ? in_data : cap_data_q;
    cap_stamp_nxt = in_valid ? (now + eff_delay) : cap_stamp_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cap_vld_q   <= 1'b0;
      cap_data_q  <= '0;
      cap_stamp_q <= '0;
    end else begin
      cap_vld_q   <= cap_vld_nxt;
      cap_data_q  <= cap_data_nxt;
      cap_stamp_q <= cap_stamp_nxt;
    end
  end

  dly_stamp_fifo #(
    .DATA_W  (DATA_W),
    .STAMP_W (DELAY_BITS),
    .DEPTH   (DEPTH)
  ) u_fifo (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (cap_vld_q),
    .wr_data    (cap_data_q),
    .wr_stamp   (cap_stamp_q),
    .rd_en      (rd_en),
    .head_data  (head_data),
    .head_stamp (head_stamp),
    .empty      (empty),
    .count      (count),
    .ovf        (overflow)
  );

  // Release: combinational pop on exact time match (wrap-safe).
  always_comb begin
    rd_en        = !empty && (head_stamp == now);
    out_vld_nxt  = rd_en;
    out_data_nxt = rd_en ? head_data : out_data_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
    end else begin
      out_vld_q  <= out_vld_nxt;
      out_data_q <= out_data_nxt;
    end
  end

  if (AFULL_EN) begin : g_afull
    assign almost_full = (count >= CNT_W'(AFULL_LEVEL));
  end else begin : g_no_afull
    assign almost_full = 1'b0;
  end

  assign out_valid = out_vld_q;
  assign out_data  = out_data_q;

  // R2: a captured stamp always lies at least MIN_LAT-1 cycles ahead of the time base
  a_r2_min_lead: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_vld_q |-> (DELAY_BITS'(cap_stamp_q - now) >= DELAY_BITS'(MIN_LAT - 1)));

  // R6: output word is held between release pulses
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_vld_q |-> (out_data_q == $past(out_data_q)));

  // R7: almost-full implies stored words are present
  a_r7_afull_nonempty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    almost_full |-> !empty);
endmodule

// File: tb/timed_delay_fifo_tb.sv
module timed_delay_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DB = 8;
  localparam int DEPTH = 8;
  localparam int WATCHDOG = 50000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic [DB-1:0] delay_cfg;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          almost_full;
  logic          overflow;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R9";
  logic [DW-1:0] exp_data[$];
  int            exp_due[$];
  logic [DW-1:0] last_out = '0;
  bit            done = 1'b0;

  timed_delay_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .delay_cfg(delay_cfg), .out_valid(out_valid), .out_data(out_data),
    .almost_full(almost_full), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Release monitor: every pulse must match the head of the expected list.
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (exp_data.size() == 0) begin
        check(cur_req, 32'(out_data), 32'hDEAD, "unexpected release");
      end else begin
        check(cur_req, 32'(out_data), 32'(exp_data[0]), "released word");
        check(cur_req, 32'(cyc), 32'(exp_due[0]), "release cycle");
        last_out = exp_data[0];
        void'(exp_data.pop_front());
        void'(exp_due.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic int eff(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  // Called at a negedge; returns at the negedge after the sampling edge.
  task automatic put_word(input logic [DW-1:0] d, input int dly, input bit expect_out);
    in_valid  = 1'b1;
    in_data   = d;
    delay_cfg = DB'(dly);
    @(posedge clk);
    @(negedge clk);
    if (expect_out) begin
      exp_data.push_back(d);
      exp_due.push_back(cyc + eff(dly));
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req, input int maxc);
    idle(maxc);
    check(req, 32'(exp_data.size()), 32'd0, "words still pending");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    exp_data.delete();
    exp_due.delete();
    repeat (3) @(negedge clk);
    check("R9", {29'd0, out_valid, almost_full, overflow}, 32'd0, "outputs in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", {29'd0, out_valid, almost_full, overflow}, 32'd0, "outputs after reset");
  endtask

  task automatic t_basic();
    cur_req = "R1";
    put_word(16'hA5C3, 10, 1);
    drain("R1", 14);
    cur_req = "R6";
    check("R6", 32'(out_valid), 32'd0, "valid low in gap");
    check("R6", 32'(out_data), 32'hA5C3, "data held after release");
  endtask

  task automatic t_clamp();
    cur_req = "R2";
    put_word(16'h0101, 0, 1);
    idle(5);
    put_word(16'h0202, 1, 1);
    drain("R2", 6);
  endtask

  task automatic t_max();
    cur_req = "R3";
    for (int k = 0; k < 3; k++) begin
      put_word(16'h3000 + 16'(k), 255, 1);
      idle(100);
      check("R3", 32'(exp_data.size()), 32'd1, "no early release");
      drain("R3", 160);
    end
  endtask

  task automatic t_stream();
    cur_req = "R4";
    for (int k = 0; k < 40; k++) put_word(16'h4000 + 16'(k), 5, 1);
    drain("R4", 10);
  endtask

  task automatic t_change();
    cur_req = "R5";
    for (int k = 0; k < 4; k++) put_word(16'h5000 + 16'(k), 3, 1);
    drain("R5", 6);
    for (int k = 0; k < 6; k++) put_word(16'h5100 + 16'(k), 30, 1);
    drain("R5", 34);
  endtask

  task automatic t_afull();
    cur_req = "R7";
    for (int k = 0; k < 5; k++) put_word(16'h7000 + 16'(k), 60, 1);
    idle(3);
    check("R7", 32'(almost_full), 32'd0, "five stored");
    put_word(16'h7005, 60, 1);
    idle(3);
    check("R7", 32'(almost_full), 32'd1, "six stored");
    drain("R7", 70);
    check("R7", 32'(almost_full), 32'd0, "after drain");
  endtask

  task automatic t_overflow();
    cur_req = "R8";
    check("R8", 32'(overflow), 32'd0, "clear before fill");
    for (int k = 0; k < DEPTH + 3; k++) put_word(16'h8000 + 16'(k), 100, k < DEPTH);
    idle(3);
    check("R8", 32'(overflow), 32'd1, "set after drop");
    check("R8", 32'(almost_full), 32'd1, "full storage");
    drain("R8", 110);
    check("R8", 32'(overflow), 32'd1, "sticky after drain");
    cur_req = "R9";
    do_reset();
  endtask

  initial begin
    in_valid = 1'b0;
    in_data = '0;
    delay_cfg = '0;
    do_reset();
    t_basic();
    t_clamp();
    t_max();
    t_stream();
    t_change();
    t_afull();
    t_overflow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule